// File: doc/BRIEF.md
# CD Drive Serial Sample Receiver

This block takes the three-wire serial output of a CD drive signal processor, plus that processor's per-bit C2 error line, and turns it into a stream of tagged bytes. A bit clock, a word clock and the serial data are brought into the system clock domain and sampled there. The receiver finds the edges of both clocks and shifts the data into a 16-bit word. Each word is then handed on as two bytes. Every byte carries an error flag, a left/right channel tag and an upper/lower tag.

The strobe edge, the bit order, the word-clock polarity, the number of bit clocks in each word period and the byte presentation order are all run-time configuration inputs. Change them only while `enable_i` is low. The system clock must run at least four times faster than the bit clock.

Top module: `cd_serial_rx`

## Requirements
- R1: With `cfg_rise_i` = 1, data and the error line are sampled on rising bit-clock edges. With `cfg_rise_i` = 0, they are sampled on falling edges.
- R2: With `cfg_lsb_first_i` = 1, the first bit of a word is bit 0 of the sample. With `cfg_lsb_first_i` = 0, the first bit is bit 15.
- R3: `byte_left_o` is 1 for a word received while the word clock was low if `cfg_left_low_i` = 1. It is 1 for a word received while the word clock was high if `cfg_left_low_i` = 0.
- R4: `cfg_frame_i` gives the bit-clock strobes per word: 00 = 16, 01 = 24, 10 or 11 = 32. A word is produced at a word-clock transition only when exactly that many strobes occurred since the previous transition. Only the last 16 strobes carry the sample. Earlier strobes, and their error flags, are ignored.
- R5: Each word yields two bytes on consecutive cycles, the upper byte (bits 15:8) tagged `byte_upper_o` = 1 and the lower byte (bits 7:0) tagged 0. The lower byte comes first when `cfg_lower_first_i` = 1; otherwise the upper byte comes first.
- R6: `byte_err_o` is the OR of the error-line samples taken with that byte's eight data bits.
- R7: `byte_valid_o` is high for exactly one system clock per byte, and exactly two bytes leave for each accepted word.
- R8: While `enable_i` is low, no byte is produced. Strobes seen while disabled are not counted, so the first word-clock transition after enabling only starts framing.
- R9: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Reception enable |
| cfg_rise_i | input | 1 | Strobe on rising (1) or falling (0) bit-clock edge |
| cfg_lsb_first_i | input | 1 | Serial word arrives LSB first (1) or MSB first (0) |
| cfg_left_low_i | input | 1 | Left channel while word clock low (1) or high (0) |
| cfg_frame_i | input | 2 | Bit clocks per word: 00=16, 01=24, 1x=32 |
| cfg_lower_first_i | input | 1 | Present lower byte first (1) or upper first (0) |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Word clock, asynchronous |
| data_i | input | 1 | Serial data |
| c2_i | input | 1 | Per-bit error flag from the signal processor |
| byte_valid_o | output | 1 | One-cycle byte strobe |
| byte_o | output | 8 | Byte value |
| byte_err_o | output | 1 | Error flag of this byte |
| byte_left_o | output | 1 | Byte belongs to the left channel |
| byte_upper_o | output | 1 | Byte is the upper half of the sample |

## Verification
The assertions assume a bit clock slow enough that two strobes never fall in adjacent system cycles. They also assume word-clock transitions are at least 16 strobes apart and that the configuration does not move while a word is in flight. The stimulus holds each bit-clock level for four system clocks. Data, the error line and the word clock change only on the non-strobe edge. The configuration is changed only with `enable_i` low. The sweep covers every setting of the configuration inputs, together with frames of the wrong length and traffic sent while disabled.

// File: rtl/cd_rx_pkg.sv
package cd_rx_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned WORD_W   = 2 * BYTE_W;
  localparam int unsigned MAX_BITS = 32;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 2);

  typedef enum logic [1:0] {
    FRM_16  = 2'b00,
    FRM_24  = 2'b01,
    FRM_32  = 2'b10,
    FRM_32B = 2'b11
  } frame_mode_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] c2;
    logic              left;
  } word_t;

  function automatic logic [CNT_W-1:0] frame_bits(input logic [1:0] mode);
    case (frame_mode_e'(mode))
      FRM_16:  frame_bits = CNT_W'(16);
      FRM_24:  frame_bits = CNT_W'(24);
      default: frame_bits = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/cd_rx_sync.sv
module cd_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cd_rx_edge.sv
module cd_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_sel_i,
  input  logic bclk_s_i,
  input  logic lrck_s_i,
  output logic strobe_o,
  output logic lrck_tog_o,
  output logic lrck_prev_o
);
  logic bclk_q, lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
    end else begin
      bclk_q <= bclk_s_i;
      lrck_q <= lrck_s_i;
    end
  end

  logic rise_det, fall_det;
  assign rise_det    = bclk_s_i & ~bclk_q;
  assign fall_det    = ~bclk_s_i & bclk_q;
  assign strobe_o    = rise_sel_i ? rise_det : fall_det;
  assign lrck_tog_o  = lrck_s_i ^ lrck_q;
  assign lrck_prev_o = lrck_q;

  // bit clock must be slower than sys_clk / 4
  assert_strobe_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/cd_rx_deser.sv
module cd_rx_deser
  import cd_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       lsb_first_i,
  input  logic       left_low_i,
  input  logic [1:0] frame_i,
  input  logic       strobe_i,
  input  logic       lrck_tog_i,
  input  logic       lrck_prev_i,
  input  logic       data_i,
  input  logic       c2_i,
  output logic       load_o,
  output word_t      word_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BITS + 1);

  logic [WORD_W-1:0] sr_q, c2sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              load_q;
  word_t             word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      c2sr_q <= '0;
      cnt_q  <= CNT_SAT;
      load_q <= 1'b0;
      word_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= CNT_SAT;
      end else begin
        if (strobe_i) begin
          if (lsb_first_i) begin
            sr_q   <= {data_i, sr_q[WORD_W-1:1]};
            c2sr_q <= {c2_i, c2sr_q[WORD_W-1:1]};
          end else begin
            sr_q   <= {sr_q[WORD_W-2:0], data_i};
            c2sr_q <= {c2sr_q[WORD_W-2:0], c2_i};
          end
        end
        if (lrck_tog_i) begin
          load_q      <= (cnt_q == frame_bits(frame_i));
          word_q.data <= sr_q;
          word_q.c2   <= c2sr_q;
          word_q.left <= lrck_prev_i ^ left_low_i;
          cnt_q       <= strobe_i ? CNT_W'(1) : '0;
        end else if (strobe_i && cnt_q != CNT_SAT) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign load_o = load_q;
  assign word_o = word_q;

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_SAT);
  assert_load_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/cd_rx_emit.sv
module cd_rx_emit
  import cd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lower_first_i,
  input  logic              load_i,
  input  word_t             word_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              err_o,
  output logic              left_o,
  output logic              upper_o
);
  logic [BYTE_W-1:0] up_b, lo_b;
  logic              up_e, lo_e;
  assign up_b = word_i.data[WORD_W-1 -: BYTE_W];
  assign lo_b = word_i.data[BYTE_W-1:0];
  assign up_e = |word_i.c2[WORD_W-1 -: BYTE_W];
  assign lo_e = |word_i.c2[BYTE_W-1:0];

  logic              valid_q, err_q, left_q, upper_q, pend_q;
  logic              hold_err_q, hold_upper_q;
  logic [BYTE_W-1:0] byte_q, hold_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      byte_q       <= '0;
      err_q        <= 1'b0;
      left_q       <= 1'b0;
      upper_q      <= 1'b0;
      pend_q       <= 1'b0;
      hold_byte_q  <= '0;
      hold_err_q   <= 1'b0;
      hold_upper_q <= 1'b0;
    end else if (load_i) begin
      valid_q      <= 1'b1;
      left_q       <= word_i.left;
      pend_q       <= 1'b1;
      byte_q       <= lower_first_i ? lo_b : up_b;
      err_q        <= lower_first_i ? lo_e : up_e;
      upper_q      <= ~lower_first_i;
      hold_byte_q  <= lower_first_i ? up_b : lo_b;
      hold_err_q   <= lower_first_i ? up_e : lo_e;
      hold_upper_q <= lower_first_i;
    end else if (pend_q) begin
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
      byte_q  <= hold_byte_q;
      err_q   <= hold_err_q;
      upper_q <= hold_upper_q;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = byte_q;
  assign err_o   = err_q;
  assign left_o  = left_q;
  assign upper_o = upper_q;

  assert_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pend_q) |=> valid_o);
  assert_first_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pend_q) |-> (upper_o == !lower_first_i));
  assert_upper_alternates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pend_q) |-> (upper_o != $past(upper_o)));
endmodule

// File: rtl/cd_serial_rx.sv
module cd_serial_rx
  import cd_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              cfg_rise_i,
  input  logic              cfg_lsb_first_i,
  input  logic              cfg_left_low_i,
  input  logic [1:0]        cfg_frame_i,
  input  logic              cfg_lower_first_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              data_i,
  input  logic              c2_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_err_o,
  output logic              byte_left_o,
  output logic              byte_upper_o
);
  localparam int unsigned N_SYNC = 4;

  logic [N_SYNC-1:0] pins_s;
  logic              strobe, lrck_tog, lrck_prev, load;
  word_t             word;

  // data and flag share the clock path latency so sampling stays aligned
  cd_rx_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({c2_i, data_i, lrck_i, bclk_i}),
    .q_o    (pins_s)
  );

  cd_rx_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_sel_i  (cfg_rise_i),
    .bclk_s_i    (pins_s[0]),
    .lrck_s_i    (pins_s[1]),
    .strobe_o    (strobe),
    .lrck_tog_o  (lrck_tog),
    .lrck_prev_o (lrck_prev)
  );

  cd_rx_deser u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .lsb_first_i (cfg_lsb_first_i),
    .left_low_i  (cfg_left_low_i),
    .frame_i     (cfg_frame_i),
    .strobe_i    (strobe),
    .lrck_tog_i  (lrck_tog),
    .lrck_prev_i (lrck_prev),
    .data_i      (pins_s[2]),
    .c2_i        (pins_s[3]),
    .load_o      (load),
    .word_o      (word)
  );

  cd_rx_emit u_emit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lower_first_i (cfg_lower_first_i),
    .load_i        (load),
    .word_i        (word),
    .valid_o       (byte_valid_o),
    .byte_o        (byte_o),
    .err_o         (byte_err_o),
    .left_o        (byte_left_o),
    .upper_o       (byte_upper_o)
  );

  assert_idle_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !$past(enable_i) && !$past(enable_i, 2) && !$past(enable_i, 3))
      |-> !byte_valid_o);
endmodule

// File: tb/cd_serial_rx_tb_top.sv
module cd_serial_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cfg_rise = 1'b1, cfg_lsb = 1'b0, cfg_lol = 1'b0, cfg_lf = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic bclk = 1'b0, lrck = 1'b0, sdata = 1'b0, c2 = 1'b0;
  logic byte_valid, byte_err, byte_left, byte_upper;
  logic [7:0] byte_val;

  int checks = 0, fails = 0;
  bit done = 0;
  logic lrck_cur = 1'b0;
  bit have_pend = 0;
  logic [15:0] pend_w, pend_c;
  logic pend_left;
  logic [10:0] exp_q[$];
  logic [10:0] got_q[$];

  always #10 clk = ~clk;

  cd_serial_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .cfg_rise_i(cfg_rise), .cfg_lsb_first_i(cfg_lsb), .cfg_left_low_i(cfg_lol),
    .cfg_frame_i(cfg_mode), .cfg_lower_first_i(cfg_lf),
    .bclk_i(bclk), .lrck_i(lrck), .data_i(sdata), .c2_i(c2),
    .byte_valid_o(byte_valid), .byte_o(byte_val), .byte_err_o(byte_err),
    .byte_left_o(byte_left), .byte_upper_o(byte_upper)
  );

  always @(negedge clk)
    if (byte_valid) got_q.push_back({byte_left, byte_upper, byte_err, byte_val});

  function automatic int frame_n(input logic [1:0] m);
    return (m == 2'b00) ? 16 : (m == 2'b01) ? 24 : 32;
  endfunction

  task automatic push_pend();
    logic [10:0] up_e, lo_e;
    if (have_pend) begin
      up_e = {pend_left, 1'b1, |pend_c[15:8], pend_w[15:8]};
      lo_e = {pend_left, 1'b0, |pend_c[7:0], pend_w[7:0]};
      if (cfg_lf) begin exp_q.push_back(lo_e); exp_q.push_back(up_e); end
      else        begin exp_q.push_back(up_e); exp_q.push_back(lo_e); end
    end
    have_pend = 0;
  endtask

  // one bit: change on the non-strobe edge, strobe four clocks later
  task automatic bit_phase(input logic d, input logic c, input logic l);
    @(negedge clk);
    bclk = ~cfg_rise; sdata = d; c2 = c; lrck = l;
    repeat (4) @(negedge clk);
    bclk = cfg_rise;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input int n, input logic [15:0] w, input logic [15:0] c);
    logic lvl;
    lvl = ~lrck_cur;
    push_pend();
    for (int i = 0; i < n; i++) begin
      if (i < n - 16) begin
        bit_phase(i[0], 1'b1, lvl);  // padding bits carry a set error flag (R4)
      end else begin
        int k, p;
        k = i - (n - 16);
        p = cfg_lsb ? k : 15 - k;
        bit_phase(w[p], c[p], lvl);
      end
    end
    lrck_cur = lvl;
    if (en && n == frame_n(cfg_mode)) begin
      have_pend = 1; pend_w = w; pend_c = c; pend_left = lvl ^ cfg_lol;
    end
  endtask

  task automatic flush();
    push_pend();
    bit_phase(1'b0, 1'b0, ~lrck_cur);
    lrck_cur = ~lrck_cur;
    repeat (10) @(negedge clk);
  endtask

  task automatic reconfig(input logic r, input logic l, input logic o, input logic f,
                          input logic [1:0] m);
    @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    cfg_rise = r; cfg_lsb = l; cfg_lol = o; cfg_lf = f; cfg_mode = m;
    repeat (4) @(negedge clk);
    en = 1'b1;
    have_pend = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_q(input string tag);
    int n;
    checks++;
    if (got_q.size() != exp_q.size()) begin
      fails++;
      $display("FAIL %s R7 byte count: got %0d expected %0d", tag, got_q.size(), exp_q.size());
    end
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      checks++;
      if (got_q[i] !== exp_q[i]) begin
        fails++;
        $display("FAIL %s byte %0d: got %h expected %h {left,upper,err,byte}",
                 tag, i, got_q[i], exp_q[i]);
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({byte_valid, byte_val, byte_err, byte_left, byte_upper} !== 12'h000) begin
      fails++;
      $display("FAIL R9 in reset: got %h expected 000",
               {byte_valid, byte_val, byte_err, byte_left, byte_upper});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({byte_valid, byte_val, byte_err, byte_left, byte_upper} !== 12'h000) begin
      fails++;
      $display("FAIL R9 after reset: got %h expected 000",
               {byte_valid, byte_val, byte_err, byte_left, byte_upper});
    end

    // R1 R2 R3 R5 R6: sweep of every configuration
    for (int cb = 0; cb < 64; cb++) begin
      logic [5:0] b;
      b = 6'(cb);
      reconfig(b[0], b[1], b[2], b[3], b[5:4]);
      for (int h = 0; h < 3; h++) begin
        logic [15:0] w, c;
        w = 16'hA5C3 ^ (16'(cb) * 16'h1357) ^ (16'(h) * 16'h2E4B);
        c = (h == 0) ? 16'h0000 : (h == 1) ? (16'h0001 << (cb % 16))
                                           : (16'h0001 << ((cb + 8) % 16));
        send_half(frame_n(b[5:4]), w, c);
      end
      flush();
      check_q("sweep R1 R2 R3 R5 R6");
    end

    // R4: words whose strobe count does not match the frame mode are dropped
    reconfig(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    send_half(16, 16'h1234, 16'h0000);
    send_half(20, 16'hDEAD, 16'h0000);
    send_half(16, 16'h5678, 16'h0100);
    flush();
    check_q("R4 mode16");
    reconfig(1'b0, 1'b1, 1'b1, 1'b1, 2'b01);
    send_half(24, 16'hC0DE, 16'h0000);
    send_half(16, 16'hBAD1, 16'h0000);
    send_half(32, 16'hBAD2, 16'h0000);
    send_half(24, 16'h9ABC, 16'h0080);
    flush();
    check_q("R4 mode24");

    // R8: traffic while disabled yields nothing, and is not counted afterwards
    reconfig(1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    en = 1'b0;
    send_half(16, 16'h1111, 16'h0000);
    send_half(16, 16'h2222, 16'h0000);
    flush();
    check_q("R8 disabled");
    en = 1'b1;
    have_pend = 0;
    repeat (4) @(negedge clk);
    send_half(16, 16'h3333, 16'h0000);
    send_half(16, 16'h4444, 16'hFFFF);
    flush();
    check_q("R8 re-enabled");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule